// File: doc/BRIEF.md
# Page-Bounded Serial Character Mover

This block moves characters between a 32-bit word-wide memory port and one serial channel, one character per memory word. A one-cycle start pulse, sampled together with a direction flag and a start address, launches a transfer. The start address is always used with its two low bits cleared.

In the transmit direction the block reads consecutive words and hands one byte lane of each word to the serial side as a character. It keeps going until the next word address would cross a page edge. In the receive direction it drains a small receive FIFO that sits inside the block. It writes every character to memory as a whole word with that byte copied into all four lanes. It stops when the FIFO runs dry or the next address would cross a half-page edge, whichever comes first.

Characters from the serial line enter the FIFO through a push strobe. When loopback is enabled during a transmit, each character that is sent is also pushed into the same FIFO. At the end of every transfer a one-cycle completion pulse is given. At that point the byte count reports four times the number of words moved.

Top module: `serial_page_dma`

## Requirements
- R1: While reset is active and after its release, `busy`, `done`, `mem_req` and `tx_valid` are low and `byte_count` is zero until a start is accepted.
- R2: Every memory address is the start address with bits 1:0 cleared, plus 4 per completed word, in ascending order. A word completes only in a cycle with `mem_req` and `mem_ready` both high. While `mem_ready` is low, `mem_req` and `mem_addr` hold.
- R3: In transmit (`dir_rx`=0), each completed read produces a one-cycle `tx_valid` in the following cycle, with `tx_char` equal to bits 15:8 of the word that was read.
- R4: Transmit ends after the word whose next address has bits [TX_PAGE_BITS-1:2] all zero. It therefore moves (2^TX_PAGE_BITS − (addr mod 2^TX_PAGE_BITS))/4 words.
- R5: While `loopback_en` is high, each character sent in transmit is pushed into the receive FIFO. While `loopback_en` is low, nothing is pushed.
- R6: In receive (`dir_rx`=1), the block writes (`mem_we`=1) one word per FIFO character, oldest first. Each word holds the character in all four byte lanes. Receive ends when the FIFO is empty.
- R7: Receive also ends after the word whose next address has bits [RX_PAGE_BITS-1:2] all zero. Characters that are not moved stay in the FIFO for the next receive.
- R8: When `done` is high, `byte_count` equals four times the words moved, in both directions. It holds that value until the next accepted start.
- R9: `done` is high for exactly one cycle per transfer. `busy` is high from the cycle after an accepted start through the `done` cycle, and `mem_req` is never high while `busy` is low.
- R10: A start pulse while `busy` is high is ignored. The running transfer keeps its direction, addresses and length.
- R11: A line push (`rx_in_valid`) into a full FIFO (FIFO_DEPTH characters held) is dropped. A loopback push into a full FIFO is dropped the same way.
- R12: A receive started with an empty FIFO makes no memory access and completes with `byte_count` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, sampled when idle |
| dir_rx | input | 1 | 1 = receive (FIFO to memory), 0 = transmit |
| start_addr | input | ADDR_W | First byte address; bits 1:0 are ignored |
| loopback_en | input | 1 | Copy sent characters into the receive FIFO |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| byte_count | output | TX_PAGE_BITS+1 | Four times the words moved |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word-aligned access address |
| mem_wdata | output | 32 | Write data (replicated character) |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |
| tx_valid | output | 1 | Character strobe toward the serial line |
| tx_char | output | 8 | Character sent |
| rx_in_valid | input | 1 | Character push from the serial line |
| rx_in_char | input | 8 | Character received |

## Verification
The bench builds the block with TX_PAGE_BITS=6, RX_PAGE_BITS=5 and FIFO_DEPTH=4. A page is then 16 words and a half page 8 words. With pages this small, every possible start offset inside a page can be swept in both directions for several memory wait-state counts. The sweeps also cover every FIFO fill level from empty to full against every receive offset, so both the early FIFO-empty stop and the half-page stop are reached. With a four-deep FIFO, overflow from the line and from loopback is reached with only a few characters.

// File: rtl/spdma_pkg.sv
package spdma_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_TX   = 2'd1,
    S_RX   = 2'd2,
    S_FIN  = 2'd3
  } spdma_state_e;

  function automatic logic [31:0] spdma_fill(input logic [7:0] c);
    return {c, c, c, c};
  endfunction

endpackage

// File: rtl/spdma_rx_fifo.sv
module spdma_rx_fifo #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       push,
  input  logic [7:0] push_char,
  input  logic       pop,
  output logic       empty,
  output logic [7:0] head
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [7:0]    store [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign do_push = push && (cnt_q != FULL);
  assign do_pop  = pop && (cnt_q != '0);
  assign empty   = (cnt_q == '0);
  assign head    = store[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) store[wr_q] <= push_char;
  end

endmodule

// File: rtl/spdma_addr_step.sv
module spdma_addr_step #(
  parameter int ADDR_W       = 32,
  parameter int TX_PAGE_BITS = 12,
  parameter int RX_PAGE_BITS = 11
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_rx,
  output logic [ADDR_W-1:0] next_addr,
  output logic              at_edge
);
  localparam logic [ADDR_W-1:0] WORD = ADDR_W'(4);

  logic tx_edge, rx_edge;

  assign next_addr = addr + WORD;
  assign tx_edge   = (next_addr[TX_PAGE_BITS-1:2] == '0);
  assign rx_edge   = (next_addr[RX_PAGE_BITS-1:2] == '0);
  assign at_edge   = is_rx ? rx_edge : tx_edge;

endmodule

// File: rtl/spdma_ctrl.sv
module spdma_ctrl
  import spdma_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int WORDS_W = 11
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               start,
  input  logic               dir_rx,
  input  logic [ADDR_W-1:0]  start_addr,
  input  logic               fifo_empty,
  input  logic               mem_ready,
  input  logic [7:0]         rd_lane,
  input  logic [ADDR_W-1:0]  step_next,
  input  logic               step_edge,
  output logic [ADDR_W-1:0]  addr,
  output logic               is_rx,
  output logic               busy,
  output logic               done,
  output logic               mem_req,
  output logic               mem_we,
  output logic               fifo_pop,
  output logic               tx_valid,
  output logic [7:0]         tx_char,
  output logic [WORDS_W-1:0] words
);
  spdma_state_e        state_q, state_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [WORDS_W-1:0]  words_q, words_d;
  logic                rx_q, rx_d;
  logic                txv_q, txv_d;
  logic [7:0]          txc_q, txc_d;
  logic                txc_en;
  logic                word_done;

  assign word_done = mem_req && mem_ready;

  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    words_d  = words_q;
    rx_d     = rx_q;
    txv_d    = 1'b0;
    txc_d    = txc_q;
    txc_en   = 1'b0;
    fifo_pop = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          addr_d  = {start_addr[ADDR_W-1:2], 2'b00};
          words_d = '0;
          rx_d    = dir_rx;
          state_d = dir_rx ? S_RX : S_TX;
        end
      end
      S_TX: begin
        if (word_done) begin
          txv_d   = 1'b1;
          txc_d   = rd_lane;
          txc_en  = 1'b1;
          addr_d  = step_next;
          words_d = words_q + 1'b1;
          if (step_edge) state_d = S_FIN;
        end
      end
      S_RX: begin
        if (fifo_empty) begin
          state_d = S_FIN;
        end else if (word_done) begin
          fifo_pop = 1'b1;
          addr_d   = step_next;
          words_d  = words_q + 1'b1;
          if (step_edge) state_d = S_FIN;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      words_q <= '0;
      rx_q    <= 1'b0;
      txv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      words_q <= words_d;
      rx_q    <= rx_d;
      txv_q   <= txv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      txc_q <= '0;
    end else if (txc_en) begin
      txc_q <= txc_d;
    end
  end

  assign addr     = addr_q;
  assign is_rx    = rx_q;
  assign busy     = (state_q != S_IDLE);
  assign done     = (state_q == S_FIN);
  assign mem_req  = (state_q == S_TX) || ((state_q == S_RX) && !fifo_empty);
  assign mem_we   = (state_q == S_RX);
  assign tx_valid = txv_q;
  assign tx_char  = txc_q;
  assign words    = words_q;

endmodule

// File: rtl/serial_page_dma.sv
module serial_page_dma
  import spdma_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int TX_PAGE_BITS = 12,
  parameter int RX_PAGE_BITS = 11,
  parameter int FIFO_DEPTH   = 16,
  parameter int TX_LANE      = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    dir_rx,
  input  logic [ADDR_W-1:0]       start_addr,
  input  logic                    loopback_en,
  output logic                    busy,
  output logic                    done,
  output logic [TX_PAGE_BITS:0]   byte_count,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [31:0]             mem_wdata,
  input  logic [31:0]             mem_rdata,
  input  logic                    mem_ready,
  output logic                    tx_valid,
  output logic [7:0]              tx_char,
  input  logic                    rx_in_valid,
  input  logic [7:0]              rx_in_char
);
  localparam int WORDS_W = TX_PAGE_BITS - 1;

  logic [1:0]         rst_sync_q;
  logic               rst_ni;
  logic               fifo_empty, fifo_pop, fifo_push;
  logic [7:0]         fifo_head, fifo_char;
  logic [ADDR_W-1:0]  addr, step_next;
  logic               step_edge, is_rx;
  logic [WORDS_W-1:0] words;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // Loopback copy takes the FIFO write slot over a line character.
  assign fifo_push = (tx_valid && loopback_en) || rx_in_valid;
  assign fifo_char = (tx_valid && loopback_en) ? tx_char : rx_in_char;

  spdma_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .push      (fifo_push),
    .push_char (fifo_char),
    .pop       (fifo_pop),
    .empty     (fifo_empty),
    .head      (fifo_head)
  );

  spdma_addr_step #(
    .ADDR_W       (ADDR_W),
    .TX_PAGE_BITS (TX_PAGE_BITS),
    .RX_PAGE_BITS (RX_PAGE_BITS)
  ) u_step (
    .addr      (addr),
    .is_rx     (is_rx),
    .next_addr (step_next),
    .at_edge   (step_edge)
  );

  spdma_ctrl #(.ADDR_W(ADDR_W), .WORDS_W(WORDS_W)) u_ctrl (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .start      (start),
    .dir_rx     (dir_rx),
    .start_addr (start_addr),
    .fifo_empty (fifo_empty),
    .mem_ready  (mem_ready),
    .rd_lane    (mem_rdata[TX_LANE*8 +: 8]),
    .step_next  (step_next),
    .step_edge  (step_edge),
    .addr       (addr),
    .is_rx      (is_rx),
    .busy       (busy),
    .done       (done),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .fifo_pop   (fifo_pop),
    .tx_valid   (tx_valid),
    .tx_char    (tx_char),
    .words      (words)
  );

  assign mem_addr   = addr;
  assign mem_wdata  = spdma_fill(fifo_head);
  assign byte_count = {words, 2'b00};

endmodule

// File: rtl/spdma_checker.sv
module spdma_checker #(
  parameter int ADDR_W  = 32,
  parameter int TX_LANE = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic [31:0]       mem_rdata,
  input logic              tx_valid,
  input logic [7:0]        tx_char
);
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

  p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  p_tx_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && !mem_we) |=>
      (tx_valid && tx_char == $past(mem_rdata[TX_LANE*8 +: 8])));

  p_rx_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |->
      (mem_wdata[31:24] == mem_wdata[7:0] && mem_wdata[23:16] == mem_wdata[7:0]
       && mem_wdata[15:8] == mem_wdata[7:0]));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_no_req_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  p_done_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

endmodule

bind serial_page_dma spdma_checker #(.ADDR_W(ADDR_W), .TX_LANE(TX_LANE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_rdata (mem_rdata),
  .tx_valid  (tx_valid),
  .tx_char   (tx_char)
);

// File: tb/serial_page_dma_test.sv
module serial_page_dma_test;
  localparam int AW    = 32;
  localparam int TXB   = 6;
  localparam int RXB   = 5;
  localparam int DEPTH = 4;
  localparam int PAGE  = 1 << TXB;
  localparam int HALF  = 1 << RXB;
  localparam int WD    = 150000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start, dir_rx, loopback_en;
  logic [AW-1:0] start_addr;
  logic          busy, done, mem_req, mem_we, mem_ready, tx_valid;
  logic [TXB:0]  byte_count;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;
  logic [7:0]    tx_char, rx_in_char;
  logic          rx_in_valid;

  always #10 clk = ~clk;

  serial_page_dma #(
    .ADDR_W(AW), .TX_PAGE_BITS(TXB), .RX_PAGE_BITS(RXB),
    .FIFO_DEPTH(DEPTH), .TX_LANE(1)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_rx(dir_rx),
    .start_addr(start_addr), .loopback_en(loopback_en), .busy(busy),
    .done(done), .byte_count(byte_count), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .tx_valid(tx_valid),
    .tx_char(tx_char), .rx_in_valid(rx_in_valid), .rx_in_char(rx_in_char)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int lat     = 0;
  int wait_cnt = 0;
  int done_cnt = 0;
  int done_bc  = 0;
  logic [AW-1:0] rd_q[$];
  logic [AW-1:0] wa_q[$];
  logic [31:0]   wd_q[$];
  logic [7:0]    tx_q[$];
  logic [7:0]    model[$];

  function automatic logic [31:0] pat(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'h3C, a[7:0] + 8'h11, a[9:2] ^ 8'hA5, ~a[7:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Memory model: acknowledges after lat idle cycles, one cycle of ready
  always @(negedge clk) begin
    cyc++;
    if (mem_ready) begin
      mem_ready = 1'b0;
      wait_cnt  = 0;
    end else if (mem_req) begin
      if (wait_cnt >= lat) begin
        if (mem_we) begin
          wa_q.push_back(mem_addr);
          wd_q.push_back(mem_wdata);
        end else begin
          rd_q.push_back(mem_addr);
          mem_rdata = pat(mem_addr);
        end
        mem_ready = 1'b1;
      end else begin
        wait_cnt++;
      end
    end
    if (tx_valid) tx_q.push_back(tx_char);
    if (done) begin
      done_cnt++;
      done_bc = int'(byte_count);
    end
    if (cyc == WD) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic clear_logs();
    rd_q.delete(); wa_q.delete(); wd_q.delete(); tx_q.delete();
  endtask

  task automatic kick(input logic [AW-1:0] a, input logic rx);
    @(negedge clk);
    start = 1'b1; dir_rx = rx; start_addr = a;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int d0);
    while (done_cnt == d0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(done_cnt == d0 + 1, "R9 one done pulse", done_cnt - d0, 1);
    chk(!busy, "R9 idle after done", busy, 0);
  endtask

  task automatic push_line(input logic [7:0] c);
    @(negedge clk);
    rx_in_valid = 1'b1; rx_in_char = c;
    @(negedge clk);
    rx_in_valid = 1'b0;
    if (model.size() < DEPTH) model.push_back(c);
  endtask

  task automatic run_tx(input logic [AW-1:0] a, input logic lb);
    int d0, n;
    logic [AW-1:0] base;
    clear_logs();
    loopback_en = lb;
    d0 = done_cnt;
    base = {a[AW-1:2], 2'b00};
    n = (PAGE - int'(base % PAGE)) / 4;
    kick(a, 1'b0);
    wait_done(d0);
    loopback_en = 1'b0;
    chk(rd_q.size() == n, "R4 tx word count", rd_q.size(), n);
    chk(wa_q.size() == 0, "R4 tx no writes", wa_q.size(), 0);
    chk(done_bc == 4 * n, "R8 tx byte count", done_bc, 4 * n);
    chk(tx_q.size() == n, "R3 tx char count", tx_q.size(), n);
    for (int i = 0; i < n && i < rd_q.size() && i < tx_q.size(); i++) begin
      logic [AW-1:0] ea;
      logic [31:0] w;
      ea = base + AW'(4 * i);
      w  = pat(ea);
      chk(rd_q[i] == ea, "R2 tx address", rd_q[i], ea);
      chk(tx_q[i] == w[15:8], "R3 tx lane", tx_q[i], w[15:8]);
      if (lb && model.size() < DEPTH) model.push_back(w[15:8]);
    end
  endtask

  task automatic run_rx(input logic [AW-1:0] a, input string tag);
    int d0, n, lim;
    logic [AW-1:0] base;
    clear_logs();
    d0 = done_cnt;
    base = {a[AW-1:2], 2'b00};
    lim = (HALF - int'(base % HALF)) / 4;
    n = (model.size() < lim) ? model.size() : lim;
    kick(a, 1'b1);
    wait_done(d0);
    chk(wa_q.size() == n, {tag, " rx word count"}, wa_q.size(), n);
    chk(rd_q.size() == 0, "R6 rx no reads", rd_q.size(), 0);
    chk(done_bc == 4 * n, "R8 rx byte count", done_bc, 4 * n);
    for (int i = 0; i < n && i < wa_q.size(); i++) begin
      logic [AW-1:0] ea;
      logic [31:0] ew;
      ea = base + AW'(4 * i);
      ew = {4{model[i]}};
      chk(wa_q[i] == ea, "R2 rx address", wa_q[i], ea);
      chk(wd_q[i] == ew, "R6 rx word", wd_q[i], ew);
    end
    for (int i = 0; i < n; i++) void'(model.pop_front());
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; dir_rx = 1'b0; start_addr = '0;
    loopback_en = 1'b0; mem_ready = 1'b0; mem_rdata = '0;
    rx_in_valid = 1'b0; rx_in_char = '0;
    repeat (4) @(negedge clk);
    chk(!busy && !done, "R1 reset busy/done", {busy, done}, 0);
    chk(!mem_req && !tx_valid, "R1 reset req/tx", {mem_req, tx_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(byte_count == 0, "R1 count after reset", byte_count, 0);
    chk(!busy && !mem_req, "R1 idle after reset", {busy, mem_req}, 0);

    // R4 sweep: every start word of a page, misaligned low bits, wait states
    for (int l = 0; l < 3; l++) begin
      lat = l;
      for (int off = 0; off < PAGE / 4; off++)
        run_tx(AW'(32'h0000_1000 + 4 * off + (off % 4)), 1'b0);
    end
    lat = 0;
    // R5: no loopback means the FIFO stayed empty; R12 empty receive
    run_rx(AW'(32'h0000_3000), "R12");
    chk(wa_q.size() == 0, "R5 no loopback pushes", wa_q.size(), 0);

    // R5 loopback, short then overfilling (R11)
    run_tx(AW'(32'h0000_1000 + 52), 1'b1);
    run_rx(AW'(32'h0000_3000), "R5");
    run_tx(AW'(32'h0000_1000 + 24), 1'b1);
    chk(model.size() == DEPTH, "R11 loopback fill", model.size(), DEPTH);
    run_rx(AW'(32'h0000_3000), "R11");

    // R6/R7 sweep: every FIFO level against every half-page offset
    for (int l = 0; l < 2; l++) begin
      lat = l;
      for (int n = 0; n <= DEPTH; n++) begin
        for (int off = 0; off < HALF / 4; off++) begin
          for (int k = 0; k < n; k++) push_line(8'(16 * n + k + off * 3 + 1));
          run_rx(AW'(32'h0000_2000 + 4 * off), "R7");
          run_rx(AW'(32'h0000_3000), "R6");
          chk(model.size() == 0, "R7 leftover drained", model.size(), 0);
        end
      end
    end
    lat = 0;

    // R11 line overflow
    for (int k = 0; k < DEPTH + 2; k++) push_line(8'(8'hC0 + k));
    chk(model.size() == DEPTH, "R11 model level", model.size(), DEPTH);
    run_rx(AW'(32'h0000_3000), "R11");

    // R10 start while busy
    begin
      int d0;
      clear_logs();
      d0 = done_cnt;
      kick(AW'(32'h0000_1000), 1'b0);
      repeat (4) @(negedge clk);
      start = 1'b1; dir_rx = 1'b1; start_addr = AW'(32'h0000_5000);
      @(negedge clk);
      start = 1'b0;
      wait_done(d0);
      chk(rd_q.size() == PAGE / 4, "R10 words unchanged", rd_q.size(), PAGE / 4);
      chk(wa_q.size() == 0, "R10 no writes", wa_q.size(), 0);
      chk(rd_q[rd_q.size()-1] == AW'(32'h0000_1000 + PAGE - 4), "R10 last address",
          rd_q[rd_q.size()-1], 32'h0000_1000 + PAGE - 4);
      chk(done_bc == PAGE, "R10 byte count", done_bc, PAGE);
      repeat (3) @(negedge clk);
      chk(byte_count == TXB'(0) + PAGE, "R8 count held", byte_count, PAGE);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule